// File: doc/BRIEF.md
# Dual Reloadable Down-Counter Timer

This peripheral holds two independent down-counters behind one 32-bit register port. The two counters share one packed control word and one event-status word. Each counter has its own reload register and its own live-value register. Each counter can be switched on or off, and it can be set either to reload itself on expiry or to stop after one expiry. Its count rate comes from one of two sources: every cycle of the system clock, or a single-cycle reference strobe. That rate then passes through a divider that divides by a power of two.

A counter expires on the tick that finds it already at zero. Expiry sets a sticky event flag, and that flag drives the counter's interrupt line as a level. Software clears a flag by writing a word whose bit for that flag is zero. Bits written as one leave their flags unchanged. To get a periodic event every N ticks, software loads N-1 into both the reload and value registers and enables the counter with reload on. A one-shot delay is armed by writing the value register with reload off. A free-running time base is the all-ones value with reload on, and elapsed ticks are read as the bitwise inverse of the count.

Top module: `dual_dtimer`

## Requirements
- R1: After reset every register reads zero and both interrupt lines are low.
- R2: The control word at offset 0x00 holds these fields: enable (bit 0 for counter 0, bit 2 for counter 1), reload-enable (bits 1 and 3), reference-source select (bits 11 and 12), and a 3-bit divide exponent (bits 21:19 and 24:22). All other bits read as zero.
- R3: Counter 0 has its reload register at 0x10 and its value register at 0x14. Counter 1 uses 0x18 and 0x1C. A write to a value register loads the counter in the next cycle. A read of a value register returns the live count.
- R4: An enabled counter decrements by one on each tick. It expires on the tick that finds it at zero, so a start value of N-1 expires after N ticks.
- R5: On expiry with reload enabled, the counter loads its reload value and stays enabled.
- R6: On expiry with reload disabled, the counter stays at zero and its own enable bit clears.
- R7: The status word at 0x04 holds counter 0's flag at bit 0 and counter 1's flag at bit 8. Expiry sets the flag. Writing a 0 to a flag's bit clears that flag, and writing a 1 leaves it unchanged. An expiry in the same cycle as a clearing write leaves the flag set.
- R8: Each interrupt output (irq[0] for counter 0, irq[1] for counter 1) equals the level of its event flag.
- R9: When the source select is set, the counter advances only on cycles where ref_tick is high. When it is clear, the counter advances every cycle.
- R10: A divide exponent d makes one tick for every 2^d source events. The divider restarts whenever its counter is disabled.
- R11: A disabled counter holds its value.
- R12: Reads of unmapped offsets return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| ref_tick | input | 1 | Single-cycle reference strobe, synchronous to clk |
| irq | output | 2 | Interrupt level per counter |

## Verification
A counter value that has gone wrong appears directly at its value register, and it also shifts the edge at which irq rises by the same number of ticks. For that reason the bench checks the exact edge of each expiry, not just that one occurs. A wrong divider phase, or a wrong decision about the source, moves the first decrement by whole cycles, and the live count read just before and just after the expected edge shows this. A flag whose clear logic is wrong shows on irq in the first cycle after the status write.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;
  localparam int DATA_W = 32;
  localparam int NUM_TMR = 2;
  localparam int DIV_W = 3;
  localparam int PRE_W = 2 ** DIV_W;

  localparam int OFF_CTRL = 'h00;
  localparam int OFF_STAT = 'h04;
  localparam int OFF_TBASE = 'h10;
  localparam int OFF_TSTEP = 'h08;
  localparam int OFF_VAL = 'h04;

  localparam int EN_BIT0 = 0;
  localparam int SRC_BIT0 = 11;
  localparam int DIV_BIT0 = 19;
  localparam int FLAG_STEP = 8;

  typedef struct packed {
    logic             en;
    logic             reload;
    logic             use_ref;
    logic [DIV_W-1:0] div;
  } tmr_cfg_t;
endpackage

// File: rtl/dtimer_prescale.sv
module dtimer_prescale
  import dtimer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             use_ref,
  input  logic             ref_tick,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q, pre_d, mask;
  logic             base;

  always_comb begin
    base  = use_ref ? ref_tick : 1'b1;
    mask  = (PRE_W'(1) << div) - PRE_W'(1);
    tick  = en && base && ((pre_q & mask) == mask);
    pre_d = pre_q;
    if (!en)       pre_d = '0;
    else if (base) pre_d = pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assert_tick_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> en);
  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pre_q == '0));
endmodule

// File: rtl/dtimer_counter.sv
module dtimer_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             reload_en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             zero;

  always_comb begin
    zero   = (cnt_q == '0);
    expire = en && tick && zero;
    cnt_d  = cnt_q;
    if (load)                   cnt_d = load_val;
    else if (expire)            cnt_d = reload_en ? reload_val : '0;
    else if (en && tick)        cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  assert_halt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> $stable(cnt_q));
  assert_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !zero && !load) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && reload_en && !load) |=> (cnt_q == $past(reload_val)));
  assert_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !reload_en && !load) |=> (cnt_q == '0));
endmodule

// File: rtl/dual_dtimer.sv
module dual_dtimer
  import dtimer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ref_tick,
  output logic [1:0]        irq
);
  tmr_cfg_t         cfg_q [NUM_TMR];
  tmr_cfg_t         cfg_d [NUM_TMR];
  logic [CNT_W-1:0] rel_q [NUM_TMR];
  logic [CNT_W-1:0] rel_d [NUM_TMR];
  logic [CNT_W-1:0] cnt   [NUM_TMR];
  logic [NUM_TMR-1:0] flag_q, flag_d, tick, expire, wr_rel, wr_val;
  logic             wr, wr_ctrl, wr_stat;

  always_comb begin
    wr      = bus_en && bus_we;
    wr_ctrl = wr && (bus_addr == ADDR_W'(OFF_CTRL));
    wr_stat = wr && (bus_addr == ADDR_W'(OFF_STAT));
    for (int i = 0; i < NUM_TMR; i++) begin
      wr_rel[i] = wr && (bus_addr == ADDR_W'(OFF_TBASE + OFF_TSTEP * i));
      wr_val[i] = wr && (bus_addr == ADDR_W'(OFF_TBASE + OFF_TSTEP * i + OFF_VAL));
    end
  end

  // next state of the shared control, reload and status registers
  always_comb begin
    for (int i = 0; i < NUM_TMR; i++) begin
      cfg_d[i] = cfg_q[i];
      if (wr_ctrl) begin
        cfg_d[i].en      = bus_wdata[EN_BIT0 + 2 * i];
        cfg_d[i].reload  = bus_wdata[EN_BIT0 + 2 * i + 1];
        cfg_d[i].use_ref = bus_wdata[SRC_BIT0 + i];
        cfg_d[i].div     = bus_wdata[DIV_BIT0 + DIV_W * i +: DIV_W];
      end else if (expire[i] && !cfg_q[i].reload) begin
        cfg_d[i].en = 1'b0;
      end
      rel_d[i]  = wr_rel[i] ? CNT_W'(bus_wdata) : rel_q[i];
      flag_d[i] = (flag_q[i] && !(wr_stat && !bus_wdata[FLAG_STEP * i])) || expire[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_TMR; i++) begin
        cfg_q[i] <= '0;
        rel_q[i] <= '0;
      end
      flag_q <= '0;
    end else begin
      for (int i = 0; i < NUM_TMR; i++) begin
        cfg_q[i] <= cfg_d[i];
        rel_q[i] <= rel_d[i];
      end
      flag_q <= flag_d;
    end
  end

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    dtimer_prescale i_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (cfg_q[g].en),
      .use_ref  (cfg_q[g].use_ref),
      .ref_tick (ref_tick),
      .div      (cfg_q[g].div),
      .tick     (tick[g])
    );
    dtimer_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (cfg_q[g].en),
      .tick       (tick[g]),
      .reload_en  (cfg_q[g].reload),
      .load       (wr_val[g]),
      .load_val   (CNT_W'(bus_wdata)),
      .reload_val (rel_q[g]),
      .cnt        (cnt[g]),
      .expire     (expire[g])
    );

    assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      expire[g] |=> flag_q[g]);
    assert_oneshot_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[g] && !cfg_q[g].reload && !wr_ctrl) |=> !cfg_q[g].en);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFF_CTRL)) begin
      for (int i = 0; i < NUM_TMR; i++) begin
        bus_rdata[EN_BIT0 + 2 * i]              = cfg_q[i].en;
        bus_rdata[EN_BIT0 + 2 * i + 1]          = cfg_q[i].reload;
        bus_rdata[SRC_BIT0 + i]                 = cfg_q[i].use_ref;
        bus_rdata[DIV_BIT0 + DIV_W * i +: DIV_W] = cfg_q[i].div;
      end
    end else if (bus_addr == ADDR_W'(OFF_STAT)) begin
      for (int i = 0; i < NUM_TMR; i++) bus_rdata[FLAG_STEP * i] = flag_q[i];
    end else begin
      for (int i = 0; i < NUM_TMR; i++) begin
        if (bus_addr == ADDR_W'(OFF_TBASE + OFF_TSTEP * i))
          bus_rdata = DATA_W'(rel_q[i]);
        if (bus_addr == ADDR_W'(OFF_TBASE + OFF_TSTEP * i + OFF_VAL))
          bus_rdata = DATA_W'(cnt[i]);
      end
    end
  end

  assign irq = flag_q;

  assert_irq_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(flag_d[0]) && !$past(flag_d[1])) |-> (irq == 2'b00));
endmodule

// File: tb/test_dual_dtimer.sv
module test_dual_dtimer;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_en = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          ref_tick = 1'b0;
  logic [1:0]    irq;

  int n_chk = 0;
  int n_bad = 0;

  dual_dtimer #(.CNT_W(32), .ADDR_W(AW)) i_dual_dtimer (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ref_tick(ref_tick), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic adv(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic stop_all();
    wr(8'h00, 32'h0);
    wr(8'h04, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); check("R1 ctrl", v, 0);
    rd(8'h04, v); check("R1 status", v, 0);
    rd(8'h14, v); check("R1 value0", v, 0);
    rd(8'h1C, v); check("R1 value1", v, 0);
    check("R1 irq", {30'b0, irq}, 0);
  endtask

  task automatic t_ctrl_layout();
    logic [31:0] v;
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); check("R2 ctrl readback", v, 32'h01F8_180F);
    stop_all();
    wr(8'h10, 32'h1234_5678);
    rd(8'h10, v); check("R3 reload0 readback", v, 32'h1234_5678);
    wr(8'h1C, 32'h0000_00AB);
    rd(8'h1C, v); check("R3 value1 direct load", v, 32'hAB);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    stop_all();
    wr(8'h14, 32'd4);
    wr(8'h00, 32'h1);
    adv(4);
    check("R4 irq0 low before expiry", {31'b0, irq[0]}, 0);
    rd(8'h14, v); check("R4 value at zero", v, 0);
    adv(1);
    check("R8 irq0 high at expiry", {31'b0, irq[0]}, 1);
    rd(8'h00, v); check("R6 enable auto-cleared", v, 0);
    rd(8'h14, v); check("R6 value stays zero", v, 0);
  endtask

  task automatic t_periodic();
    logic [31:0] v;
    stop_all();
    wr(8'h10, 32'd2);
    wr(8'h14, 32'd2);
    wr(8'h00, 32'h3);
    adv(2);
    rd(8'h14, v); check("R4 periodic count", v, 0);
    adv(1);
    rd(8'h14, v); check("R5 reloaded", v, 2);
    check("R7 flag on reload expiry", {31'b0, irq[0]}, 1);
    rd(8'h00, v); check("R5 stays enabled", v, 32'h3);
  endtask

  task automatic t_flag_clear();
    logic [31:0] v;
    wr(8'h00, 32'h0);
    wr(8'h04, 32'hFFFF_FFFF);
    check("R7 ones keep flag", {31'b0, irq[0]}, 1);
    wr(8'h04, 32'hFFFF_FEFF);
    check("R7 other bit keeps flag0", {31'b0, irq[0]}, 1);
    wr(8'h04, 32'hFFFF_FFFE);
    rd(8'h04, v); check("R7 zero clears flag0", v, 0);
  endtask

  task automatic t_collision();
    stop_all();
    wr(8'h10, 32'd0);
    wr(8'h14, 32'd0);
    wr(8'h00, 32'h3);
    wr(8'h04, 32'h0);
    check("R7 expiry beats clear", {31'b0, irq[0]}, 1);
    stop_all();
    check("R8 irq0 low after clear", {31'b0, irq[0]}, 0);
  endtask

  task automatic t_ref_source();
    logic [31:0] v;
    stop_all();
    wr(8'h1C, 32'd1);
    wr(8'h00, 32'h0000_1004);
    adv(10);
    rd(8'h1C, v); check("R9 no ref, no count", v, 1);
    @(negedge clk); ref_tick = 1'b1;
    @(negedge clk); ref_tick = 1'b0;
    rd(8'h1C, v); check("R9 one ref, one decrement", v, 0);
    @(negedge clk); ref_tick = 1'b1;
    @(negedge clk); ref_tick = 1'b0;
    check("R9 irq1 after second ref", {30'b0, irq}, 32'h2);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    stop_all();
    wr(8'h14, 32'd1);
    wr(8'h00, 32'h0010_0001);
    adv(3);
    rd(8'h14, v); check("R10 no tick before 4 cycles", v, 1);
    adv(1);
    rd(8'h14, v); check("R10 tick at 4 cycles", v, 0);
    adv(3);
    check("R10 no expiry at 7", {31'b0, irq[0]}, 0);
    adv(1);
    check("R10 expiry at 8", {31'b0, irq[0]}, 1);
  endtask

  task automatic t_freerun_halt();
    logic [31:0] v, h;
    stop_all();
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h00, 32'h3);
    adv(10);
    rd(8'h14, v); check("R4 elapsed as inverse", ~v, 10);
    wr(8'h00, 32'h0);
    rd(8'h14, h);
    adv(5);
    rd(8'h14, v); check("R11 halted value stable", v, h);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    stop_all();
    wr(8'h08, 32'hDEAD_BEEF);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h08, v); check("R12 unmapped read 0x08", v, 0);
    rd(8'h20, v); check("R12 unmapped read 0x20", v, 0);
    rd(8'h00, v); check("R12 ctrl untouched", v, 0);
    rd(8'h04, v); check("R12 status untouched", v, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    adv(3);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    adv(2);
    t_reset();
    t_ctrl_layout();
    t_oneshot();
    t_periodic();
    t_flag_clear();
    t_collision();
    t_ref_source();
    t_prescale();
    t_freerun_halt();
    t_unmapped();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule